// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from up to twenty-four sources, held as three byte-wide request groups, and presents the most urgent pending one to a processor as a small vector index. Each source has a two-bit priority code. One bit of the code sits in an "upper enable" register and the other in a "lower enable" register. The code either disables the source or places it on one of three levels. When two pending sources share the top level, the one with the smaller index wins. A smaller index stands for an earlier vector address.

Requests come from three places. Peripherals send single-cycle event pulses. A byte of port pins passes through edge detectors; each detector can be set to rising edge or falling edge, and the lower pins can also be set to fire on both edges. Software can also write the request registers directly. The detector for pin 0 can take the comparator output in place of the pin, chosen by a control bit. A global enable gates delivery to the processor. Taking an interrupt clears the global enable and clears the served request bit. A return from interrupt, or software writing a 1, sets the global enable again.

The processor takes an interrupt by raising `cpu_ack` while `irq_valid` is high. The vector it took stays on `irq_vec` for as long as `cpu_ack` remains high. `irq_valid` stays low during that time.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, every register reads 0, and `irq_valid` is 0 until software changes the state.
- R2: The priority code of source i is {upper[i], lower[i]}. Code 00 means disabled, and a pending source with code 00 never raises `irq_valid`. Codes 01, 10 and 11 are levels 1, 2 and 3, and 3 is the most urgent.
- R3: `irq_vec` gives the index of a pending, enabled source on the highest level that has any pending source.
- R4: When several pending sources share the highest level, the lowest source index wins.
- R5: `irq_valid` is 1 only while the global enable (control bit 7) is set. The global enable is cleared when an interrupt is taken. It is set by a `cpu_ret` pulse or by writing control with bit 7 at 1, and cleared by writing bit 7 at 0. If a take and a return happen in the same cycle, the take wins.
- R6: An interrupt is taken when `cpu_ack` is high while `irq_valid` is 1. The request bit of the taken source is cleared. From the next cycle, for as long as `cpu_ack` stays high, `irq_vec` holds the taken index and `irq_valid` stays 0.
- R7: Writing a request register replaces its bits. A bit written as 1 raises an interrupt in the same way a hardware event does.
- R8: A hardware event for a source sets its request bit even in a cycle where a software write or a take would clear that bit.
- R9: Port pin k drives source 8+k. Edge-select bit k at 1 fires on a rising edge, and at 0 fires on a falling edge. An edge seen at a clock edge sets the request at that same clock edge.
- R10: Both-edge bit k, for pins 0 to 3 only, makes pin k fire on either edge. Bits 4 to 7 of that register cannot be set and read back as 0.
- R11: Control bit 0 at 1 feeds the comparator output into the pin 0 detector, and pin 0 is then ignored.
- R12: Register map read through `rd_addr`/`rd_data`: requests at 0 to 2, upper enables at 3 to 5, lower enables at 6 to 8, edge select at 9, both-edge at 10, control at 11. Group g holds sources 8g to 8g+7, with bit n of the group being source 8g+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_evt | input | 24 | Single-cycle request pulses, one per source |
| port_pin | input | 8 | Port pins feeding the edge detectors of group 1 |
| cmp_out | input | 1 | Comparator output, which can replace pin 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cpu_ack | input | 1 | Processor acknowledge, held high while taking |
| cpu_ret | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | An enabled request is being presented |
| irq_vec | output | 5 | Index of the presented or taken source |

## Verification
All state changes at the clock edge where the stimulus is seen. This applies to writes, pulses, pin edges, takes and returns. The registered results, and `irq_valid`/`irq_vec` derived from them, are therefore due at the falling edge that follows that rising edge. `rd_data` also follows `rd_addr` without a clock. The bench drives inputs after a falling edge and lets one rising edge pass. At the next falling edge it compares the design against its behavioural model and runs its directed checks. A read check first changes `rd_addr`, waits one time unit, and then samples.

// File: rtl/irq_prio_pkg.sv
// Package: shared types and helpers for the interrupt controller.
// Assumes priority codes are two bits wide, with 0 meaning disabled.
package irq_prio_pkg;
    typedef logic [1:0] prio_t;

    // Combine the upper/lower enable bits into a priority code.
    function automatic prio_t make_prio(input logic up, input logic lo);
        return {up, lo};
    endfunction
endpackage

// File: rtl/irq_edge_detect.sv
// Edge detectors for a byte of inputs. Each bit fires on a rising or a
// falling edge, or on both edges where BOTH_OK allows it.
// Assumes the inputs are already synchronous to clk.
module irq_edge_detect #(
    parameter int           W       = 8,
    parameter logic [W-1:0] BOTH_OK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    input  logic [W-1:0] rise_sel,
    input  logic [W-1:0] both,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise, fall, both_eff;

    // Remember the last sampled inputs; reset loads the current value so no spurious edge.
    always_ff @(posedge clk) begin
        prev_q <= sig;
    end

    // Classify edges and apply the per-bit selection.
    always_comb begin
        rise     = sig & ~prev_q;
        fall     = ~sig & prev_q;
        both_eff = both & BOTH_OK;
        evt      = (both_eff & (rise | fall))
                 | (~both_eff & rise_sel & rise)
                 | (~both_eff & ~rise_sel & fall);
        if (!rst_n) evt = '0;
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Arbiter: selects the pending source with the highest priority code.
// Ties go to the lowest index. Purely combinational.
// Assumes that code 0 means disabled.
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int N     = 24,
    parameter int VEC_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     en_up,
    input  logic [N-1:0]     en_lo,
    output logic             found,
    output logic [VEC_W-1:0] win
);
    prio_t best_lvl;
    prio_t lvl;

    // Scan upward in index; a strict compare keeps the lowest index on a tie.
    always_comb begin
        best_lvl = '0;
        win      = '0;
        lvl      = '0;
        for (int i = 0; i < N; i++) begin
            lvl = make_prio(en_up[i], en_lo[i]);
            if (pend[i] && (lvl > best_lvl)) begin
                best_lvl = lvl;
                win      = VEC_W'(i);
            end
        end
        found = (best_lvl != '0);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top level of the prioritized vectored interrupt controller: request, enable,
// edge and control registers, source steering, and the take/return handshake.
// Assumes a single synchronous clock, a synchronous active-low reset, and
// rd_data decoded combinationally.
module irq_prio_ctrl #(
    parameter  int                 NUM_GROUPS = 3,
    parameter  int                 GROUP_W    = 8,
    parameter  int                 PORT_GRP   = 1,
    parameter  logic [GROUP_W-1:0] BOTH_OK    = 8'h0F,
    parameter  int                 ADDR_W     = 4,
    localparam int                 NUM_SRC    = NUM_GROUPS * GROUP_W,
    localparam int                 VEC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_evt,
    input  logic [GROUP_W-1:0] port_pin,
    input  logic               cmp_out,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [GROUP_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [GROUP_W-1:0] rd_data,
    input  logic               cpu_ack,
    input  logic               cpu_ret,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vec
);
    localparam int A_UP   = NUM_GROUPS;
    localparam int A_LO   = 2 * NUM_GROUPS;
    localparam int A_ESEL = 3 * NUM_GROUPS;
    localparam int A_BOTH = A_ESEL + 1;
    localparam int A_CTRL = A_ESEL + 2;

    logic [NUM_SRC-1:0] req_q, up_q, lo_q, set_vec, clr_vec;
    logic [GROUP_W-1:0] esel_q, both_q, det_in, port_evt;
    logic               gie_q, steer_q, busy_q, take, found;
    logic [VEC_W-1:0]   held_q, win;

    // Route the comparator into the pin 0 detector when steering is selected.
    always_comb begin
        det_in    = port_pin;
        det_in[0] = steer_q ? cmp_out : port_pin[0];
    end

    irq_edge_detect #(.W(GROUP_W), .BOTH_OK(BOTH_OK)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig(det_in),
        .rise_sel(esel_q), .both(both_q), .evt(port_evt)
    );

    irq_prio_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .pend(req_q), .en_up(up_q), .en_lo(lo_q), .found(found), .win(win)
    );

    assign irq_valid = gie_q & found & ~busy_q;
    assign take      = cpu_ack & irq_valid;
    assign irq_vec   = busy_q ? held_q : win;

    // One-hot clear of the request being taken.
    always_comb begin
        clr_vec = '0;
        if (take) clr_vec[win] = 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            logic [GROUP_W-1:0] evt_g;
            if (g == PORT_GRP) begin : g_port
                assign evt_g = port_evt;
            end else begin : g_noport
                assign evt_g = '0;
            end
            assign set_vec[g*GROUP_W +: GROUP_W] = hw_evt[g*GROUP_W +: GROUP_W] | evt_g;

            // Request bits: a write or a take clears them, but any event in the same cycle wins.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    req_q[g*GROUP_W +: GROUP_W] <= '0;
                end else begin
                    req_q[g*GROUP_W +: GROUP_W] <=
                        (((wr_en && wr_addr == ADDR_W'(g)) ? wr_data
                                                           : req_q[g*GROUP_W +: GROUP_W])
                         & ~clr_vec[g*GROUP_W +: GROUP_W])
                        | set_vec[g*GROUP_W +: GROUP_W];
                end
            end

            // Upper and lower enable bits of this group.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    up_q[g*GROUP_W +: GROUP_W] <= '0;
                    lo_q[g*GROUP_W +: GROUP_W] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == ADDR_W'(A_UP + g)) up_q[g*GROUP_W +: GROUP_W] <= wr_data;
                    if (wr_addr == ADDR_W'(A_LO + g)) lo_q[g*GROUP_W +: GROUP_W] <= wr_data;
                end
            end
        end
    endgenerate

    // Edge-select, both-edge and steering configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esel_q  <= '0;
            both_q  <= '0;
            steer_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_ESEL)) esel_q  <= wr_data;
            if (wr_addr == ADDR_W'(A_BOTH)) both_q  <= wr_data & BOTH_OK;
            if (wr_addr == ADDR_W'(A_CTRL)) steer_q <= wr_data[0];
        end
    end

    // Global enable: a take clears it, a return sets it, and software may write it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    gie_q <= 1'b0;
        else if (take)                                 gie_q <= 1'b0;
        else if (cpu_ret)                              gie_q <= 1'b1;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))  gie_q <= wr_data[GROUP_W-1];
    end

    // Hold the taken vector for as long as the acknowledge stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            held_q <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            held_q <= win;
        end else if (!cpu_ack) begin
            busy_q <= 1'b0;
        end
    end

    // Register read decode.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_GROUPS; k++) begin
            if (rd_addr == ADDR_W'(k))        rd_data = req_q[k*GROUP_W +: GROUP_W];
            if (rd_addr == ADDR_W'(A_UP + k)) rd_data = up_q[k*GROUP_W +: GROUP_W];
            if (rd_addr == ADDR_W'(A_LO + k)) rd_data = lo_q[k*GROUP_W +: GROUP_W];
        end
        if (rd_addr == ADDR_W'(A_ESEL)) rd_data = esel_q;
        if (rd_addr == ADDR_W'(A_BOTH)) rd_data = both_q;
        if (rd_addr == ADDR_W'(A_CTRL)) begin
            rd_data[GROUP_W-1] = gie_q;
            rd_data[0]         = steer_q;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Checker: watches the take handshake at the ports of irq_prio_ctrl.
// Assumes it is attached with the bind statement at the end of this file.
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 24,
    parameter int VEC_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ack,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vec
);
    logic in_take;

    // Independent record of an open acknowledge window.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_take <= 1'b0;
        else if (irq_valid && cpu_ack)   in_take <= 1'b1;
        else if (!cpu_ack)               in_take <= 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq_valid); // R1
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_vec) < NUM_SRC)); // R3
    AST_TAKE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && cpu_ack) |=> !irq_valid); // R5
    AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && cpu_ack) |-> !irq_valid); // R6
    AST_HOLD_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && cpu_ack) |=> $stable(irq_vec)); // R6
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack),
    .irq_valid(irq_valid), .irq_vec(irq_vec)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
// Bench for irq_prio_ctrl. A behavioural model is stepped on every rising
// edge and compared at every falling edge; directed checks cover each requirement.
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] hw_evt;
    logic [7:0]  port_pin, wr_data, rd_data;
    logic        cmp_out, wr_en, cpu_ack, cpu_ret, irq_valid;
    logic [3:0]  wr_addr, rd_addr;
    logic [4:0]  irq_vec;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Model state
    bit [23:0] m_req, m_up, m_lo;
    bit [7:0]  m_esel, m_both, m_prev;
    bit        m_gie, m_steer, m_busy;
    int        m_held;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .port_pin(port_pin),
        .cmp_out(cmp_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cpu_ack(cpu_ack),
        .cpu_ret(cpu_ret), .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_win(output bit found);
        int best = 0;
        int lvl  = 0;
        m_win = 0;
        for (int i = 0; i < 24; i++) begin
            int l = 2 * int'(m_up[i]) + int'(m_lo[i]);
            if (m_req[i] && l > lvl) begin
                lvl    = l;
                best   = i;
            end
        end
        found = (lvl != 0);
        m_win = best;
    endfunction

    function automatic int m_reg(input int a);
        case (a)
            0, 1, 2: return int'(m_req[a*8 +: 8]);
            3, 4, 5: return int'(m_up[(a-3)*8 +: 8]);
            6, 7, 8: return int'(m_lo[(a-6)*8 +: 8]);
            9:       return int'(m_esel);
            10:      return int'(m_both);
            11:      return (m_gie ? 128 : 0) + (m_steer ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    // Advance the model by one clock using the inputs held at this edge.
    task automatic model_step();
        bit found, valid, take;
        int w;
        bit [7:0] det, rise, fall, pev;
        bit [23:0] nreq;
        det    = port_pin;
        det[0] = m_steer ? cmp_out : port_pin[0];
        if (!rst_n) begin
            m_req = 0; m_up = 0; m_lo = 0; m_esel = 0; m_both = 0;
            m_gie = 0; m_steer = 0; m_busy = 0; m_held = 0; m_prev = det;
            return;
        end
        w     = m_win(found);
        valid = m_gie && found && !m_busy;
        take  = cpu_ack && valid;
        rise  = det & ~m_prev;
        fall  = ~det & m_prev;
        for (int k = 0; k < 8; k++)
            pev[k] = m_both[k] ? (rise[k] | fall[k]) : (m_esel[k] ? rise[k] : fall[k]);
        nreq = m_req;
        if (wr_en && wr_addr < 3) nreq[wr_addr*8 +: 8] = wr_data;
        if (take) nreq[w] = 1'b0;
        nreq = nreq | hw_evt | (24'(pev) << 8);
        m_req = nreq;
        if (wr_en) begin
            if (wr_addr >= 3 && wr_addr <= 5) m_up[(wr_addr-3)*8 +: 8] = wr_data;
            if (wr_addr >= 6 && wr_addr <= 8) m_lo[(wr_addr-6)*8 +: 8] = wr_data;
            if (wr_addr == 9)  m_esel  = wr_data;
            if (wr_addr == 10) m_both  = wr_data & 8'h0F;
            if (wr_addr == 11) m_steer = wr_data[0];
        end
        if (take)          m_gie = 0;
        else if (cpu_ret)  m_gie = 1;
        else if (wr_en && wr_addr == 11) m_gie = wr_data[7];
        if (take) begin
            m_busy = 1; m_held = w;
        end else if (!cpu_ack) begin
            m_busy = 0;
        end
        m_prev = det;
    endtask

    // Compare outputs with the model (R3 R4 R6 are the main concerns here).
    task automatic compare();
        bit found;
        int w  = m_win(found);
        bit ev = m_gie && found && !m_busy;
        check("R3 R4 R6 model valid", int'(irq_valid), int'(ev));
        if (ev || m_busy) check("R3 R4 R6 model vec", int'(irq_vec), m_busy ? m_held : w);
        check("R12 model rd_data", int'(rd_data), m_reg(int'(rd_addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
        tick();
        wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        rd_addr = 4'(a);
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 0; hw_evt = 0; port_pin = 0; cmp_out = 0; wr_en = 0;
        wr_addr = 0; wr_data = 0; rd_addr = 0; cpu_ack = 0; cpu_ret = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 valid after reset", int'(irq_valid), 0);
        for (int a = 0; a < 12; a++) rd_chk("R1 R12 register zero", a, 0);

        // Source 3 at level 1, source 17 at level 3, global enable on
        wr(6, 8'h08);
        wr(5, 8'h02);
        wr(8, 8'h02);
        wr(11, 8'h80);
        rd_chk("R12 control readback", 11, 8'h80);
        check("R5 nothing pending", int'(irq_valid), 0);

        // R7 software-raised request
        wr(0, 8'h08);
        check("R7 software request valid", int'(irq_valid), 1);
        check("R7 software request vec", int'(irq_vec), 3);

        // R3 higher level wins
        hw_evt = 24'(1) << 17; tick(); hw_evt = 0;
        check("R3 level 3 wins", int'(irq_vec), 17);

        // R4 tie inside level 2: sources 9 and 12
        wr(0, 0); wr(2, 0);
        wr(4, 8'h12);
        wr(1, 8'h12);
        check("R4 tie lowest index", int'(irq_vec), 9);

        // R2 disabled source 20 never presented
        wr(2, 8'h10);
        check("R2 enabled still wins", int'(irq_vec), 9);
        wr(1, 0);
        check("R2 disabled not presented", int'(irq_valid), 0);
        rd_chk("R2 disabled stays pending", 2, 8'h10);

        // R6 and R5 take handshake
        wr(1, 8'h10);
        check("R6 source 12 offered", int'(irq_vec), 12);
        cpu_ack = 1; tick();
        check("R6 valid low while held", int'(irq_valid), 0);
        check("R6 vec held", int'(irq_vec), 12);
        hw_evt = 24'(1) << 17; tick(); hw_evt = 0;
        check("R6 vec held despite new request", int'(irq_vec), 12);
        tick();
        cpu_ack = 0; tick();
        check("R5 enable cleared by take", int'(irq_valid), 0);
        rd_chk("R5 control after take", 11, 0);
        rd_chk("R6 request cleared", 1, 0);
        cpu_ret = 1; tick(); cpu_ret = 0;
        check("R5 return re-enables", int'(irq_valid), 1);
        check("R5 pending 17 shown", int'(irq_vec), 17);
        wr(11, 0);
        check("R5 write 0 disables", int'(irq_valid), 0);
        wr(2, 0);

        // R8 event beats a clearing write
        wr_en = 1; wr_addr = 2; wr_data = 0; hw_evt = 24'(1) << 18;
        tick();
        wr_en = 0; hw_evt = 0;
        rd_chk("R8 event wins over write", 2, 8'h04);

        // R9 edge selection on pin 1
        wr(9, 8'h02); wr(1, 0);
        port_pin[1] = 1; tick();
        rd_chk("R9 rising edge fires", 1, 8'h02);
        wr(1, 0);
        port_pin[1] = 0; tick();
        rd_chk("R9 falling ignored when rising selected", 1, 0);
        wr(9, 0);
        port_pin[1] = 1; tick();
        rd_chk("R9 rising ignored when falling selected", 1, 0);
        port_pin[1] = 0; tick();
        rd_chk("R9 falling edge fires", 1, 8'h02);

        // R10 both-edge mode
        wr(10, 8'hFF);
        rd_chk("R10 upper bits not settable", 10, 8'h0F);
        wr(1, 0);
        port_pin[2] = 1; tick();
        rd_chk("R10 both rising", 1, 8'h04);
        wr(1, 0);
        port_pin[2] = 0; tick();
        rd_chk("R10 both falling", 1, 8'h04);
        wr(1, 0);
        port_pin[6] = 1; tick();
        rd_chk("R10 pin 6 rise ignored", 1, 0);

        // R11 comparator steering on source 8
        wr(10, 0); wr(9, 8'h01); wr(11, 8'h01); wr(1, 0);
        port_pin[0] = 1; tick();
        rd_chk("R11 pin 0 ignored when steered", 1, 0);
        cmp_out = 1; tick();
        rd_chk("R11 comparator edge fires", 1, 8'h01);

        repeat (2) tick();
        finish_run();
    end
endmodule